// File: doc/BRIEF.md
# Programmable Serial Frame Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. Software-facing logic outside the block writes a byte into a one-entry holding register and sets the framing through a handful of configuration inputs: word length (5 to 8 bits), parity on or off, parity kind (odd, even, forced one, forced zero), stop-bit selection and a transmitter-control code. All timing comes from a strobe supplied from outside at sixteen pulses per bit. The block does not divide a clock down to a baud rate, and it has no receive side.

A frame is a low start bit, then the data bits with the least significant bit first, then the optional parity bit, then a high stop period. The stop period normally lasts one or two bit times. Two word shapes change the stop length: the shortest word without parity gets one and a half bit times, and the longest word with parity gets a single bit time. The configuration is captured when a frame begins, so changing it during a frame only affects later frames. If a byte is waiting when the stop period ends, its start bit follows with no gap. One control code replaces normal output with a continuous low break level. When break is released, the line goes back high for one full bit time before any waiting byte is sent.

Top module: `sertx_core`

## Requirements
- R1: After reset the line output `txd` is high (idle) and `hold_empty` is 1.
- R2: A frame is one low start bit, then the data bits least significant bit first, each bit lasting 16 pulses of `tick16`. Between frames the line stays high.
- R3: `hold_empty` goes to 0 on the cycle after a write. It returns to 1 on the same clock edge at which the held byte moves to the shifter and the start bit begins.
- R4: If a byte is already held when a stop period ends, its start bit begins on that same tick, with no idle gap.
- R5: `cfg_len` selects the number of data bits: 00 gives 8, 01 gives 7, 10 gives 6, 11 gives 5. Only that many low bits of the byte are sent.
- R6: When `par_en` is 1, a parity bit follows the last data bit. `par_mode` 00 makes the count of ones in the data plus parity odd, 01 makes it even, 10 always sends 1 and 11 always sends 0. When `par_en` is 0, no parity bit is sent.
- R7: With `cfg_stop2` at 0 the stop period is 16 ticks. With `cfg_stop2` at 1 it is 32 ticks, except in the cases of R8.
- R8: With `cfg_stop2` at 1, a 5-bit word without parity gets a 24-tick stop period, and an 8-bit word with parity gets a 16-tick stop period.
- R9: Word length, parity and stop selection are captured when the start bit begins. Changes made during a frame do not alter that frame.
- R10: A write while the holding register is full replaces the held byte. Only the newest byte is sent, and `hold_empty` stays 0.
- R11: `tx_ctl` = 11 drives `txd` low continuously once no frame is in progress. A byte held during break stays held (`hold_empty` stays 0) and is not sent. The codes 00, 01 and 10 send normally.
- R12: When `tx_ctl` leaves 11, `txd` goes high for exactly 16 ticks. After that the held byte's start bit begins, if there is one.
- R13: The line state advances only on `tick16` pulses. A slower strobe stretches every bit in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Strobe at sixteen pulses per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_len | input | 2 | Word length code |
| cfg_stop2 | input | 1 | Stop selection (0 = one bit, 1 = long stop) |
| par_en | input | 1 | Parity bit enable |
| par_mode | input | 2 | Parity kind |
| tx_ctl | input | 2 | Transmitter control (11 = break) |
| hold_empty | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial line, idle high |

## Verification
The hardest states to reach from the ports are the seam between two frames and the exit from break. The stop length is only exact when a second byte is already waiting at the moment the stop period ends. The scoreboard therefore writes the second byte as soon as `hold_empty` rises and checks that the next falling edge comes exactly at the expected tick. It pairs the long-stop exceptions and the configuration snapshot with this chaining. For break, a byte is written while the line is held low, and the bench checks that it is held back. After release it checks the one-bit high guard cycle by cycle, then lets the scoreboard decode the delayed frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK,
      ST_GUARD
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_MARK  = 2'b10,
      PAR_SPACE = 2'b11
   } par_mode_e;

   localparam logic [1:0] CTL_BREAK = 2'b11;
   localparam logic [1:0] LEN_LONGEST  = 2'b00;
   localparam logic [1:0] LEN_SHORTEST = 2'b11;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] held
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= '0;
      end else if (wr_en) begin
         full <= 1'b1;
         held <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TPB        = 16,
   parameter bit          HAS_PARITY = 1'b1,
   localparam int unsigned IDX_W     = $clog2(DATA_W + 1),
   localparam int unsigned CNT_W     = $clog2(2 * TPB + 1)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_stop2,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   output logic [DATA_W-1:0] data_m,
   output logic [IDX_W-1:0]  nbits,
   output logic              par_on,
   output logic              par_bit,
   output logic [CNT_W-1:0]  stop_ticks
);

   localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(TPB);
   localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(TPB + TPB / 2);
   localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * TPB);

   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   assign nbits = IDX_W'(DATA_W) - IDX_W'(cfg_len);

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign mask[gi] = (IDX_W'(gi) < nbits);
   end

   assign data_m   = data & mask;
   assign ones_odd = ^data_m;

   if (HAS_PARITY) begin : g_par
      assign par_on = par_en;
      always_comb begin
         case (par_mode_e'(par_mode))
            PAR_ODD:   par_bit = ~ones_odd;
            PAR_EVEN:  par_bit = ones_odd;
            PAR_MARK:  par_bit = 1'b1;
            default:   par_bit = 1'b0;
         endcase
      end
   end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{par_en, par_mode, ones_odd};
      assign par_on  = 1'b0;
      assign par_bit = 1'b0;
   end

   always_comb begin
      if (!cfg_stop2)
         stop_ticks = STOP_ONE;
      else if (cfg_len == LEN_SHORTEST && !par_on)
         stop_ticks = STOP_HALF;
      else if (cfg_len == LEN_LONGEST && par_on)
         stop_ticks = STOP_ONE;
      else
         stop_ticks = STOP_TWO;
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned TPB    = 16,
   localparam int unsigned IDX_W = $clog2(DATA_W + 1),
   localparam int unsigned CNT_W = $clog2(2 * TPB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              brk_req,
   input  logic              full,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [IDX_W-1:0]  ld_nbits,
   input  logic              ld_par_on,
   input  logic              ld_par_bit,
   input  logic [CNT_W-1:0]  ld_stop,
   output logic              take,
   output logic              brk_active,
   output logic              txd
);

   localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(TPB);

   tx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lim;
   logic [DATA_W-1:0] sh;
   logic [IDX_W-1:0]  bidx;
   logic [IDX_W-1:0]  nb_q;
   logic              pon_q;
   logic              pbit_q;
   logic [CNT_W-1:0]  stop_q;
   logic              ticking;
   logic              last_tick;
   logic              frame_end;

   assign lim       = (st == ST_STOP) ? stop_q : BIT_TICKS;
   assign ticking   = (st == ST_START) || (st == ST_DATA) || (st == ST_PAR) ||
                      (st == ST_STOP)  || (st == ST_GUARD);
   assign last_tick = ticking && tick16 && (cnt == lim - 1'b1);
   assign frame_end = last_tick && ((st == ST_STOP) || (st == ST_GUARD));
   assign take      = ((st == ST_IDLE) || frame_end) && full && !brk_req;
   assign brk_active = (st == ST_BRK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         bidx   <= '0;
         nb_q   <= '0;
         pon_q  <= 1'b0;
         pbit_q <= 1'b0;
         stop_q <= BIT_TICKS;
      end else if (take) begin
         st     <= ST_START;
         cnt    <= '0;
         sh     <= ld_data;
         bidx   <= '0;
         nb_q   <= ld_nbits;
         pon_q  <= ld_par_on;
         pbit_q <= ld_par_bit;
         stop_q <= ld_stop;
      end else begin
         if (ticking && tick16)
            cnt <= last_tick ? '0 : cnt + 1'b1;
         case (st)
            ST_IDLE: begin
               if (brk_req) st <= ST_BRK;
            end
            ST_START: begin
               if (last_tick) begin
                  st   <= ST_DATA;
                  bidx <= '0;
               end
            end
            ST_DATA: begin
               if (last_tick) begin
                  sh   <= sh >> 1;
                  bidx <= bidx + 1'b1;
                  if (bidx == nb_q - 1'b1)
                     st <= pon_q ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: begin
               if (last_tick) st <= ST_STOP;
            end
            ST_STOP, ST_GUARD: begin
               if (last_tick) st <= ST_IDLE;
            end
            ST_BRK: begin
               if (!brk_req) begin
                  st  <= ST_GUARD;
                  cnt <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = sh[0];
         ST_PAR:   txd = pbit_q;
         ST_BRK:   txd = 1'b0;
         default:  txd = 1'b1;
      endcase
   end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TPB        = 16,
   parameter bit          HAS_PARITY = 1'b1,
   localparam int unsigned IDX_W     = $clog2(DATA_W + 1),
   localparam int unsigned CNT_W     = $clog2(2 * TPB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_stop2,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   input  logic [1:0]        tx_ctl,
   output logic              hold_empty,
   output logic              txd
);

   if (DATA_W < 4) begin : g_bad_width
      $error("sertx_core: DATA_W must be at least 4");
   end
   if (TPB < 2 || (TPB % 2) != 0) begin : g_bad_tpb
      $error("sertx_core: TPB must be even and at least 2");
   end

   logic              full;
   logic              take;
   logic              brk_on;
   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] data_m;
   logic [IDX_W-1:0]  nbits;
   logic              par_on;
   logic              par_bit;
   logic [CNT_W-1:0]  stop_ticks;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .full    (full),
      .held    (held)
   );

   sertx_frame #(.DATA_W(DATA_W), .TPB(TPB), .HAS_PARITY(HAS_PARITY)) u_frame (
      .data       (held),
      .cfg_len    (cfg_len),
      .cfg_stop2  (cfg_stop2),
      .par_en     (par_en),
      .par_mode   (par_mode),
      .data_m     (data_m),
      .nbits      (nbits),
      .par_on     (par_on),
      .par_bit    (par_bit),
      .stop_ticks (stop_ticks)
   );

   sertx_shift #(.DATA_W(DATA_W), .TPB(TPB)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .brk_req    (tx_ctl == CTL_BREAK),
      .full       (full),
      .ld_data    (data_m),
      .ld_nbits   (nbits),
      .ld_par_on  (par_on),
      .ld_par_bit (par_bit),
      .ld_stop    (stop_ticks),
      .take       (take),
      .brk_active (brk_on),
      .txd        (txd)
   );

   assign hold_empty = ~full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick16,
   input logic       wr_en,
   input logic [1:0] tx_ctl,
   input logic       hold_empty,
   input logic       txd,
   input logic       brk_on
);

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty); // R10

   AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> !txd); // R3

   AST_HOLD_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_on && !hold_empty) |=> !hold_empty); // R11

   AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick16 && hold_empty && tx_ctl != 2'b11 && $past(tx_ctl) != 2'b11)
         |=> $stable(txd)); // R13

endmodule

bind sertx_core sertx_chk i_sertx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick16     (tick16),
   .wr_en      (wr_en),
   .tx_ctl     (tx_ctl),
   .hold_empty (hold_empty),
   .txd        (txd),
   .brk_on     (brk_on)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;

   typedef struct {
      logic [7:0] data;
      int         nb;
      bit         pon;
      bit         pbit;
      int         stop;
      int         div;
      bit         follows;
      string      tag;
      string      stag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] cfg_len = 2'b00;
   logic       cfg_stop2 = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic [1:0] tx_ctl = 2'b00;
   logic       hold_empty;
   logic       txd;

   int   n_run = 0;
   int   n_fail = 0;
   int   tick_div = 1;
   int   tdc = 0;
   bit   mon_en = 1'b1;
   int   mpos = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   sertx_core i_sertx_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .cfg_len    (cfg_len),
      .cfg_stop2  (cfg_stop2),
      .par_en     (par_en),
      .par_mode   (par_mode),
      .tx_ctl     (tx_ctl),
      .hold_empty (hold_empty),
      .txd        (txd)
   );

   always @(posedge clk) begin
      if (tdc >= tick_div - 1) begin
         tdc    <= 0;
         tick16 <= 1'b1;
      end else begin
         tdc    <= tdc + 1;
         tick16 <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(negedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   // Expected item built from the requirements and the current settings
   task automatic push_exp(input logic [7:0] d, input bit follows, input string tag);
      exp_t e;
      int   ones;
      e.data = d;
      e.nb   = 8 - int'(cfg_len);
      e.pon  = par_en;
      ones   = 0;
      for (int k = 0; k < e.nb; k++) ones += d[k];
      case (par_mode)
         2'b00:   e.pbit = (ones % 2) == 0;
         2'b01:   e.pbit = (ones % 2) == 1;
         2'b10:   e.pbit = 1'b1;
         default: e.pbit = 1'b0;
      endcase
      e.stag = "R7";
      if (!cfg_stop2) e.stop = 16;
      else if (e.nb == 5 && !par_en) begin e.stop = 24; e.stag = "R8"; end
      else if (e.nb == 8 && par_en)  begin e.stop = 16; e.stag = "R8"; end
      else e.stop = 32;
      e.div     = tick_div;
      e.follows = follows;
      e.tag     = tag;
      q.push_back(e);
   endtask

   task automatic wr_raw(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input bit follows, input string tag);
      @(negedge clk);
      while (!hold_empty) @(negedge clk);
      push_exp(d, follows, tag);
      wr_raw(d);
   endtask

   task automatic wait_taken();
      @(negedge clk);
      while (!hold_empty) @(negedge clk);
   endtask

   task automatic wait_done();
      while (q.size() != 0) @(negedge clk);
      repeat (16 * 13 * tick_div + 40) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [1:0] len, input bit s2, input bit pe,
                          input logic [1:0] pm, input logic [1:0] ctl);
      cfg_len   = len;
      cfg_stop2 = s2;
      par_en    = pe;
      par_mode  = pm;
      tx_ctl    = ctl;
   endtask

   task automatic mon_adv(input int target);
      while (mpos < target) begin
         @(negedge clk);
         mpos++;
      end
   endtask

   // Monitor: decodes each frame from the line and compares with the queue
   initial begin : monitor
      exp_t e;
      bit   last;
      bit   pend;
      bit   allhi;
      int   b;
      int   s;
      last = 1'b1;
      pend = 1'b0;
      forever begin
         if (!pend) begin
            @(negedge clk);
            while (!(mon_en && last && !txd)) begin
               last = txd;
               @(negedge clk);
            end
         end
         pend = 1'b0;
         if (q.size() == 0) begin
            chk(1'b0, "R2 unexpected start bit", 1, 0);
            last = txd;
         end else begin
            e    = q.pop_front();
            b    = 16 * e.div;
            mpos = 0;
            mon_adv(b / 2);
            chk(txd == 1'b0, {e.tag, " R2 start bit low"}, int'(txd), 0);
            for (int k = 0; k < e.nb; k++) begin
               mon_adv(b * (1 + k) + b / 2);
               chk(txd == e.data[k], $sformatf("%s R2/R5 data bit %0d", e.tag, k),
                   int'(txd), int'(e.data[k]));
            end
            if (e.pon) begin
               mon_adv(b * (1 + e.nb) + b / 2);
               chk(txd == e.pbit, {e.tag, " R6 parity bit"}, int'(txd), int'(e.pbit));
            end
            s     = b * (1 + e.nb + int'(e.pon));
            allhi = 1'b1;
            for (int t = s + e.div; t <= s + e.stop * e.div - e.div; t++) begin
               mon_adv(t);
               if (txd !== 1'b1) allhi = 1'b0;
            end
            chk(allhi, {e.tag, " ", e.stag, " stop period high"}, int'(allhi), 1);
            if (e.follows) begin
               mon_adv(s + e.stop * e.div);
               chk(txd == 1'b0, {e.tag, " R4 next start right after stop (",
                   e.stag, " length)"}, int'(txd), 0);
               if (txd == 1'b0) pend = 1'b1;
            end
            last = txd;
         end
      end
   end

   initial begin : driver
      bit ok;
      repeat (5) @(negedge clk);
      chk(txd == 1'b1, "R1 line idle high in reset", int'(txd), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R1 line idle high after reset", int'(txd), 1);
      chk(hold_empty == 1'b1, "R1 holding register empty", int'(hold_empty), 1);

      // 8 data bits, no parity, one stop; back-to-back; tx_ctl 01 and 10 send (R11)
      set_cfg(2'b00, 1'b0, 1'b0, 2'b00, 2'b01);
      send(8'hA5, 1'b1, "R2");
      wait_taken();
      tx_ctl = 2'b10;
      send(8'h3C, 1'b0, "R11 ctl10");
      wait_done();

      // word length and parity modes
      set_cfg(2'b01, 1'b0, 1'b1, 2'b01, 2'b00);
      send(8'hDB, 1'b0, "R5 len7 even");
      wait_done();
      set_cfg(2'b10, 1'b0, 1'b1, 2'b00, 2'b00);
      send(8'hED, 1'b0, "R6 len6 odd");
      wait_done();
      set_cfg(2'b11, 1'b0, 1'b1, 2'b10, 2'b00);
      send(8'hF1, 1'b0, "R6 len5 mark");
      wait_done();
      set_cfg(2'b11, 1'b0, 1'b1, 2'b11, 2'b00);
      send(8'h1F, 1'b0, "R6 len5 space");
      wait_done();

      // stop lengths measured by chaining
      set_cfg(2'b00, 1'b1, 1'b0, 2'b00, 2'b00);
      send(8'hF0, 1'b1, "R7 8N2");
      wait_taken();
      send(8'h0F, 1'b0, "R7 8N2 b");
      wait_done();
      set_cfg(2'b11, 1'b1, 1'b0, 2'b00, 2'b00);
      send(8'h15, 1'b1, "R8 5N1.5");
      wait_taken();
      send(8'h0A, 1'b0, "R8 5N1.5 b");
      wait_done();
      set_cfg(2'b00, 1'b1, 1'b1, 2'b01, 2'b00);
      send(8'h81, 1'b1, "R8 8E stop2");
      wait_taken();
      send(8'h7E, 1'b0, "R8 8E stop2 b");
      wait_done();
      set_cfg(2'b10, 1'b1, 1'b1, 2'b01, 2'b00);
      send(8'h2A, 1'b1, "R7 6E2");
      wait_taken();
      send(8'h15, 1'b0, "R7 6E2 b");
      wait_done();

      // R9: configuration changed while the first frame runs
      set_cfg(2'b00, 1'b0, 1'b1, 2'b01, 2'b00);
      send(8'hC3, 1'b1, "R9 first");
      wait_taken();
      set_cfg(2'b11, 1'b1, 1'b1, 2'b00, 2'b00);
      send(8'h19, 1'b0, "R9 second");
      wait_done();

      // R10: overwrite of a full holding register
      set_cfg(2'b00, 1'b0, 1'b0, 2'b00, 2'b00);
      send(8'h11, 1'b1, "R10 first");
      wait_taken();
      wr_raw(8'h22);
      chk(hold_empty == 1'b0, "R3 hold_empty low after write", int'(hold_empty), 0);
      push_exp(8'h99, 1'b0, "R10 newest");
      wr_raw(8'h99);
      chk(hold_empty == 1'b0, "R10 still full after overwrite", int'(hold_empty), 0);
      wait_done();

      // R11/R12: break
      mon_en = 1'b0;
      @(negedge clk);
      tx_ctl = 2'b11;
      repeat (5) @(negedge clk);
      chk(txd == 1'b0, "R11 break drives line low", int'(txd), 0);
      wr_raw(8'h5A);
      ok = 1'b1;
      repeat (100) begin
         @(negedge clk);
         if (txd !== 1'b0 || hold_empty !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R11 line low and byte held during break", int'(ok), 1);
      tx_ctl = 2'b00;
      push_exp(8'h5A, 1'b0, "R12 after break");
      mon_en = 1'b1;
      ok = 1'b1;
      repeat (16) begin
         @(negedge clk);
         if (txd !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R12 guard high for 16 ticks", int'(ok), 1);
      @(negedge clk);
      chk(txd == 1'b0, "R12 held byte starts after guard", int'(txd), 0);
      wait_done();

      // R13: strobe at half rate stretches every bit
      tick_div = 2;
      set_cfg(2'b00, 1'b0, 1'b1, 2'b00, 2'b00);
      send(8'h96, 1'b0, "R13 half rate");
      wait_done();

      chk(q.size() == 0, "R2 all expected frames seen", q.size(), 0);
      chk(txd == 1'b1, "R2 line idle high at end", int'(txd), 1);
      finish_run();
   end

endmodule